// File: doc/BRIEF.md
# Power-Up Soft-Start Sequencer

This block brings up the reference codes of a two-rail voltage regulator controller. It waits until the main bias flag, both driver bias flags and the digitized enable input are all high. It then freezes the core phase count and the target codes, holds both reference codes at zero for a fixed delay, and raises each code by one DAC step per fixed tick interval until that rail reaches its own target. Once every active rail has arrived, power-good goes high.

The operating mode is taken from the mode-select pin only on a rising edge of enable. In serial mode, both the core rail and the north-bridge rail ramp, and their targets come from the serial VID path. In parallel mode, only the core rail ramps, toward the parallel VID target, and the north-bridge rail stays off at code zero. If any bias flag falls or enable drops, the sequence aborts at once and returns to idle.

Top module: `softstart_seq`

## Requirements
- R1: After reset, both reference codes are 0, power-good is 0, both rail enables are 0 and the phase count output is 3.
- R2: No sequence starts while any of the three bias flags or enable is low. The core enable and both codes then stay at 0.
- R3: The mode is sampled from modeSel only in the cycle in which enable rises (1 = serial, 0 = parallel). Changes of modeSel while enable stays high have no effect, including when a sequence restarts after bias returns.
- R4: At sequence start, the phase count output is loaded as follows: 1 if phSense3 and phSense4 are both high (2 phases), 2 if only phSense4 is high (3 phases), and 3 otherwise (4 phases). It holds that value until the next start.
- R5: The targets are captured in the start cycle: svTargetCore/svTargetNb in serial mode, pvTargetCore in parallel mode. Later changes of the target inputs have no effect on the running sequence.
- R6: After the start edge, both codes stay 0 for DELAY_CYCLES clock cycles while coreEn is high.
- R7: After the delay, each active rail's code rises by exactly 1 every STEP_CYCLES cycles. Each rail stops independently at its own captured target.
- R8: In parallel mode, nbEn stays 0 and nbCode stays 0. In serial mode, nbEn is high for the whole sequence.
- R9: powerGood rises one cycle after the last active rail reaches its target. It stays high while the inputs stay good.
- R10: When any bias flag or enable is low at a clock edge, that edge returns both codes to 0 and drops powerGood, coreEn and nbEn.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| biasMainOk | input | 1 | Main bias above its power-on threshold |
| biasDrvAOk | input | 1 | First driver bias above its threshold |
| biasDrvBOk | input | 1 | Second driver bias above its threshold |
| enable | input | 1 | Digitized enable comparator output |
| modeSel | input | 1 | Mode select, 1 = serial, 0 = parallel |
| phSense3 | input | 1 | Phase-sense input for channel 3 (high = channel absent) |
| phSense4 | input | 1 | Phase-sense input for channel 4 (high = channel absent) |
| svTargetCore | input | CODE_W | Core target from the serial VID path |
| svTargetNb | input | CODE_W | North-bridge target from the serial VID path |
| pvTargetCore | input | CODE_W | Core target from the parallel VID path |
| coreCode | output | CODE_W | Core reference DAC code |
| nbCode | output | CODE_W | North-bridge reference DAC code |
| coreEn | output | 1 | Core rail active |
| nbEn | output | 1 | North-bridge rail active |
| phaseCnt | output | 2 | Latched core phase count minus one |
| powerGood | output | 1 | All active rails at target |

## Verification
Counting from the start edge E0, at which the block captures its inputs, a code equals min(target, floor((k - DELAY_CYCLES) / STEP_CYCLES)) one time unit after edge Ek for k at or above DELAY_CYCLES, and 0 before that. powerGood is due after edge E(DELAY_CYCLES + maxTarget*STEP_CYCLES + 1), and an abort is visible after the first edge that sees the bad input. The bench drives inputs on falling edges and samples shortly after each rising edge. It checks every cycle of every sequence against these closed-form values, so each result is compared in exactly the cycle it is due.

// File: rtl/ss_pkg.sv
package ss_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_DELAY = 2'd1,
    ST_RAMP  = 2'd2,
    ST_DONE  = 2'd3
  } seqState_t;

  typedef struct packed {
    logic clear;    // drop codes to zero (abort)
    logic capture;  // freeze mode, phases and targets
    logic step;     // advance ramping codes by one LSB
  } seqStrobe_t;
endpackage

// File: rtl/ss_ctrl.sv
module ss_ctrl
  import ss_pkg::*;
#(
  parameter int DELAY_CYCLES = 25000,
  parameter int STEP_CYCLES  = 481
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       allOk,
  input  logic       railsDone,
  output seqStrobe_t strobe,
  output logic       running,
  output logic       powerGood
);
  localparam int DLY_W  = $clog2(DELAY_CYCLES + 1);
  localparam int TICK_W = $clog2(STEP_CYCLES + 1);
  localparam logic [DLY_W-1:0]  DLY_LAST  = DLY_W'(DELAY_CYCLES - 1);
  localparam logic [TICK_W-1:0] TICK_LAST = TICK_W'(STEP_CYCLES - 1);

  seqState_t state;
  logic [DLY_W-1:0]  delayCnt;
  logic [TICK_W-1:0] tickCnt;

  always_comb begin
    strobe.clear   = !allOk;
    strobe.capture = allOk && (state == ST_IDLE);
    strobe.step    = allOk && (state == ST_RAMP) && (tickCnt == TICK_LAST);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      delayCnt <= '0;
      tickCnt  <= '0;
    end else if (!allOk) begin
      state    <= ST_IDLE;
      delayCnt <= '0;
      tickCnt  <= '0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          state    <= ST_DELAY;
          delayCnt <= '0;
        end
        ST_DELAY: begin
          if (delayCnt == DLY_LAST) begin
            state   <= ST_RAMP;
            tickCnt <= '0;
          end else begin
            delayCnt <= delayCnt + 1'b1;
          end
        end
        ST_RAMP: begin
          if (railsDone) state <= ST_DONE;
          tickCnt <= (tickCnt == TICK_LAST) ? '0 : tickCnt + 1'b1;
        end
        default: state <= ST_DONE;
      endcase
    end
  end

  assign running   = (state != ST_IDLE);
  assign powerGood = (state == ST_DONE);

  AST_ABORT_TO_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    !allOk |=> (state == ST_IDLE)); // R10
  AST_NO_START_GATED: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE && !allOk) |=> !running); // R2
  AST_PG_NEEDS_DONE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(powerGood) |-> $past(railsDone)); // R9
endmodule

// File: rtl/ss_dpath.sv
module ss_dpath
  import ss_pkg::*;
#(
  parameter int CODE_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqStrobe_t        strobe,
  input  logic              enable,
  input  logic              modeSel,
  input  logic              phSense3,
  input  logic              phSense4,
  input  logic [CODE_W-1:0] svTargetCore,
  input  logic [CODE_W-1:0] svTargetNb,
  input  logic [CODE_W-1:0] pvTargetCore,
  output logic [CODE_W-1:0] coreCode,
  output logic [CODE_W-1:0] nbCode,
  output logic              nbActive,
  output logic [1:0]        phaseCnt,
  output logic              railsDone
);
  logic enPrev, modeLatched, enRise, modeNow;
  logic [1:0] phaseNext;
  logic [CODE_W-1:0] coreTgt, nbTgt;

  assign enRise  = enable & ~enPrev;
  assign modeNow = enRise ? modeSel : modeLatched;

  always_comb begin
    if (phSense4 && phSense3)  phaseNext = 2'd1;
    else if (phSense4)         phaseNext = 2'd2;
    else                       phaseNext = 2'd3;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enPrev      <= 1'b0;
      modeLatched <= 1'b0;
    end else begin
      enPrev <= enable;
      if (enRise) modeLatched <= modeSel;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      coreTgt  <= '0;
      nbTgt    <= '0;
      nbActive <= 1'b0;
      phaseCnt <= 2'd3;
    end else if (strobe.capture) begin
      coreTgt  <= modeNow ? svTargetCore : pvTargetCore;
      nbTgt    <= modeNow ? svTargetNb : '0;
      nbActive <= modeNow;
      phaseCnt <= phaseNext;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      coreCode <= '0;
      nbCode   <= '0;
    end else if (strobe.clear || strobe.capture) begin
      coreCode <= '0;
      nbCode   <= '0;
    end else if (strobe.step) begin
      if (coreCode < coreTgt)            coreCode <= coreCode + 1'b1;
      if (nbActive && (nbCode < nbTgt))  nbCode   <= nbCode + 1'b1;
    end
  end

  assign railsDone = (coreCode == coreTgt) && (!nbActive || (nbCode == nbTgt));

  AST_CORE_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    coreCode <= coreTgt); // R7
  AST_CORE_UNIT_STEP: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.clear |=> (coreCode == $past(coreCode) || coreCode == $past(coreCode) + 1'b1)); // R7
  AST_NB_OFF_PARALLEL: assert property (@(posedge clk) disable iff (!rstN)
    !nbActive |-> (nbCode == '0)); // R8
  AST_TARGET_FROZEN: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.capture |=> ($stable(coreTgt) && $stable(nbTgt))); // R5
  AST_PHASE_HELD: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.capture |=> $stable(phaseCnt)); // R4
  AST_MODE_ON_RISE: assert property (@(posedge clk) disable iff (!rstN)
    !enRise |=> $stable(modeLatched)); // R3
endmodule

// File: rtl/softstart_seq.sv
module softstart_seq
  import ss_pkg::*;
#(
  parameter int CODE_W       = 8,
  parameter int DELAY_CYCLES = 25000,
  parameter int STEP_CYCLES  = 481
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              biasMainOk,
  input  logic              biasDrvAOk,
  input  logic              biasDrvBOk,
  input  logic              enable,
  input  logic              modeSel,
  input  logic              phSense3,
  input  logic              phSense4,
  input  logic [CODE_W-1:0] svTargetCore,
  input  logic [CODE_W-1:0] svTargetNb,
  input  logic [CODE_W-1:0] pvTargetCore,
  output logic [CODE_W-1:0] coreCode,
  output logic [CODE_W-1:0] nbCode,
  output logic              coreEn,
  output logic              nbEn,
  output logic [1:0]        phaseCnt,
  output logic              powerGood
);
  seqStrobe_t strobe;
  logic allOk, railsDone, running, nbActive;

  assign allOk = biasMainOk & biasDrvAOk & biasDrvBOk & enable;

  ss_ctrl #(
    .DELAY_CYCLES(DELAY_CYCLES),
    .STEP_CYCLES (STEP_CYCLES)
  ) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .allOk    (allOk),
    .railsDone(railsDone),
    .strobe   (strobe),
    .running  (running),
    .powerGood(powerGood)
  );

  ss_dpath #(
    .CODE_W(CODE_W)
  ) u_dpath (
    .clk         (clk),
    .rstN        (rstN),
    .strobe      (strobe),
    .enable      (enable),
    .modeSel     (modeSel),
    .phSense3    (phSense3),
    .phSense4    (phSense4),
    .svTargetCore(svTargetCore),
    .svTargetNb  (svTargetNb),
    .pvTargetCore(pvTargetCore),
    .coreCode    (coreCode),
    .nbCode      (nbCode),
    .nbActive    (nbActive),
    .phaseCnt    (phaseCnt),
    .railsDone   (railsDone)
  );

  assign coreEn = running;
  assign nbEn   = running & nbActive;

  AST_IDLE_NO_PG: assert property (@(posedge clk) disable iff (!rstN)
    !coreEn |-> (!powerGood && coreCode == '0 && nbCode == '0)); // R10
endmodule

// File: tb/softstart_seq_tb.sv
module softstart_seq_tb;
  localparam int W = 6;
  localparam int D = 10;
  localparam int S = 3;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic biasMainOk = 1'b0, biasDrvAOk = 1'b0, biasDrvBOk = 1'b0;
  logic enable = 1'b0, modeSel = 1'b0, phSense3 = 1'b0, phSense4 = 1'b0;
  logic [W-1:0] svTargetCore = '0, svTargetNb = '0, pvTargetCore = '0;
  logic [W-1:0] coreCode, nbCode;
  logic coreEn, nbEn, powerGood;
  logic [1:0] phaseCnt;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  softstart_seq #(.CODE_W(W), .DELAY_CYCLES(D), .STEP_CYCLES(S)) u_dut (
    .clk(clk), .rstN(rstN),
    .biasMainOk(biasMainOk), .biasDrvAOk(biasDrvAOk), .biasDrvBOk(biasDrvBOk),
    .enable(enable), .modeSel(modeSel), .phSense3(phSense3), .phSense4(phSense4),
    .svTargetCore(svTargetCore), .svTargetNb(svTargetNb), .pvTargetCore(pvTargetCore),
    .coreCode(coreCode), .nbCode(nbCode), .coreEn(coreEn), .nbEn(nbEn),
    .phaseCnt(phaseCnt), .powerGood(powerGood)
  );

  function automatic int expCode(int k, int tgt);
    if (k < D) return 0;
    return ((k - D) / S < tgt) ? (k - D) / S : tgt;
  endfunction

  function automatic int expPhase(logic p3, logic p4);
    if (p4 && p3) return 1;
    if (p4)       return 2;
    return 3;
  endfunction

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // Called with the start inputs already set; E0 is the next rising edge.
  task automatic runSeq(logic serial, int tc, int tn, int ph);
    int tmax;
    tmax = serial ? ((tc > tn) ? tc : tn) : tc;
    @(posedge clk); #1;
    // scramble inputs after capture: must have no effect (R3, R4, R5)
    modeSel      = ~modeSel;
    phSense3     = ~phSense3;
    phSense4     = ~phSense4;
    svTargetCore = W'($urandom);
    svTargetNb   = W'($urandom);
    pvTargetCore = W'($urandom);
    for (int k = 1; k <= D + tmax * S + 3; k++) begin
      @(posedge clk); #1;
      if (k == 1) begin
        chk("R4 phaseCnt", int'(phaseCnt), ph);
        chk("R8 nbEn", int'(nbEn), int'(serial));
      end
      if (k < D) chk("R6 delay coreEn", int'(coreEn), 1);
      chk("R5/R7 coreCode", int'(coreCode), expCode(k, tc));
      chk("R7/R8 nbCode", int'(nbCode), serial ? expCode(k, tn) : 0);
      chk("R9 powerGood", int'(powerGood), int'(k >= D + tmax * S + 1));
    end
  endtask

  task automatic restartWith(logic serial, int tc, int tn, logic p3, logic p4);
    @(negedge clk);
    enable = 1'b0;
    repeat (2) @(negedge clk);
    modeSel = serial; phSense3 = p3; phSense4 = p4;
    svTargetCore = W'(tc); svTargetNb = W'(tn); pvTargetCore = W'(tc);
    enable = 1'b1;
    runSeq(serial, tc, tn, expPhase(p3, p4));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int seed;
    seed = $urandom(32'd20240611);
    repeat (3) @(posedge clk);
    #1;
    // R1 reset state
    chk("R1 coreCode", int'(coreCode), 0);
    chk("R1 nbCode", int'(nbCode), 0);
    chk("R1 powerGood", int'(powerGood), 0);
    chk("R1 enables", int'({coreEn, nbEn}), 0);
    chk("R1 phaseCnt", int'(phaseCnt), 3);
    @(negedge clk); rstN = 1'b1;

    // R2: one driver flag low blocks start; enable rises here with serial mode
    biasMainOk = 1'b1; biasDrvAOk = 1'b1; biasDrvBOk = 1'b0;
    modeSel = 1'b1; phSense3 = 1'b0; phSense4 = 1'b1;
    svTargetCore = W'(5); svTargetNb = W'(8); pvTargetCore = W'(2);
    enable = 1'b1;
    repeat (6) @(posedge clk);
    #1;
    chk("R2 coreEn gated", int'(coreEn), 0);
    chk("R2 coreCode gated", int'(coreCode), 0);
    // R3: mode flips with enable held high; latched serial must win
    @(negedge clk);
    modeSel = 1'b0; biasDrvBOk = 1'b1;
    runSeq(1'b1, 5, 8, 2);

    // R10: abort mid-ramp by main bias loss
    @(negedge clk);
    enable = 1'b0;
    repeat (2) @(negedge clk);
    modeSel = 1'b1; svTargetCore = W'(30); svTargetNb = W'(30);
    enable = 1'b1;
    repeat (D + 4 * S + 1) @(posedge clk);
    @(negedge clk); biasMainOk = 1'b0;
    @(posedge clk); #1;
    chk("R10 coreCode", int'(coreCode), 0);
    chk("R10 nbCode", int'(nbCode), 0);
    chk("R10 enables", int'({coreEn, nbEn}), 0);
    chk("R10 powerGood", int'(powerGood), 0);
    repeat (4) @(posedge clk); #1;
    chk("R2 no start without main bias", int'(coreEn), 0);
    @(negedge clk); biasMainOk = 1'b1;

    // directed corners: zero targets, full-scale core, parallel mode
    restartWith(1'b1, 0, 0, 1'b1, 1'b1);
    restartWith(1'b0, 63, 40, 1'b0, 1'b0);
    restartWith(1'b1, 3, 0, 1'b1, 1'b0);

    // R10: enable drop after power-good
    @(negedge clk); enable = 1'b0;
    @(posedge clk); #1;
    chk("R10 enable drop pg", int'(powerGood), 0);
    chk("R10 enable drop code", int'(coreCode), 0);

    // constrained random runs
    for (int i = 0; i < 8; i++) begin
      restartWith(1'($urandom), int'($urandom % 21), int'($urandom % 21),
                  1'($urandom), 1'($urandom));
    end

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule